// File: doc/BRIEF.md
# Atomic Event Ordering Monitor

This block sits beside the retire stage and watches memory instructions that form one multi-line atomic event. A locked load seen while idle opens an event. Each locked load during setup adds its cache line to a small table of participating lines. Lines are compared on the address bits above a 64-byte offset. The event moves from setup to manifestation either on a query instruction or on the first store to a participating line. It ends on the single store that carries the lock bit.

Any break in that order, or a demand for more lines than the table holds, ends the event with a one-cycle fault pulse and a 3-bit cause. The table clears in the same cycle as the fault. A plain load seen after manifestation has begun is allowed, but it raises an advisory warning flag. The monitor only reports what it sees. It holds no data and does not undo anything.

Top module: `atomic_order_monitor`

## Requirements
- R1: After reset, `evt_active`, `evt_done`, `flt_pulse` and `late_load_warn` are 0, `flt_cause` is 0 and `line_count` is 0.
- R2: While idle, only a locked load (`in_op`=0, `in_lock`=1) opens an event. It sets `evt_active` and gives `line_count`=1 one cycle later. While idle, stores (`in_op`=1), queries (`in_op`=2) and plain loads change nothing.
- R3: During setup, a locked load to a line that is not yet recorded raises `line_count` by one. A locked load that matches a recorded line in `in_addr` bits [ADDR_W-1:6] leaves the count unchanged.
- R4: When `line_count` equals DEPTH (8), a locked load to a new line raises a fault with cause 2 (capacity). A locked load to a line already recorded raises no fault.
- R5: A query during setup starts manifestation. Any later locked load in that event raises a fault with cause 1 (order).
- R6: With no query seen, a plain store to a participating line starts manifestation. A later locked load then faults with cause 1.
- R7: A query seen during manifestation, whether a second query or a query after a store, faults with cause 1.
- R8: A store, locked or plain, to a line not in the table faults with cause 3 (foreign line).
- R9: A locked store to a participating line gives a one-cycle `evt_done` pulse with no fault. In the same cycle `evt_active` drops and `line_count` returns to 0. This holds in setup as well as in manifestation.
- R10: A plain load during manifestation sets `late_load_warn` without a fault. The flag stays set until the next event opens. A plain load during setup leaves the flag clear.
- R11: Beats with `in_valid`=0, and beats of class other (`in_op`=3), change neither `evt_active` nor `line_count`.
- R12: A fault is a one-cycle `flt_pulse` with a nonzero `flt_cause`. In the same cycle `evt_active` drops and `line_count` is 0. `flt_cause` is 0 whenever `flt_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat valid |
| in_op | input | 2 | Class: 0 load, 1 store, 2 query, 3 other |
| in_lock | input | 1 | Lock bit of the beat |
| in_addr | input | ADDR_W | Byte address of the access |
| evt_active | output | 1 | An event is open |
| evt_done | output | 1 | One-cycle pulse on completion |
| flt_pulse | output | 1 | One-cycle fault pulse |
| flt_cause | output | 3 | Fault cause: 1 order, 2 capacity, 3 foreign line |
| late_load_warn | output | 1 | Plain load seen after manifestation began |
| line_count | output | CNT_W | Number of participating lines |

## Verification
A locked store that arrives while the event is still in setup does two things in one beat: it starts manifestation and it completes the event. The bench opens an event and then sends the locked store straight after it, with no query and no plain store in between. It then expects a done pulse with no fault, a cleared count and an idle monitor. A second collision happens when a fault and the table clear land together. The capacity and order tests judge this by reading a zero count in the same cycle as the fault pulse.

// File: rtl/aom_pkg.sv
package aom_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_QUERY = 2'd2,
    OP_OTHER = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    CZ_NONE     = 3'd0,
    CZ_ORDER    = 3'd1,
    CZ_CAPACITY = 3'd2,
    CZ_FOREIGN  = 3'd3
  } cause_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_MANIF = 2'd2
  } phase_e;
endpackage

// File: rtl/aom_line_table.sv
module aom_line_table #(
  parameter int TAG_W = 42,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lookup_tag,
  input  logic             ins_en,
  input  logic             clr_en,
  output logic             hit,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_d;
  logic [DEPTH-1:0] match;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             do_ins;

  assign do_ins = ins_en && !clr_en && !hit && !full;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic slot_sel;
    assign slot_sel = do_ins && (cnt_q == CNT_W'(g));
    assign match[g] = vld_q[g] && (tag_q[g] == lookup_tag);

    always_comb begin
      vld_d[g] = vld_q[g];
      if (clr_en)        vld_d[g] = 1'b0;
      else if (slot_sel) vld_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tag_q[g] <= '0;
      else if (slot_sel) tag_q[g] <= lookup_tag;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr_en)      cnt_d = '0;
    else if (do_ins) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_d;
      cnt_q <= cnt_d;
    end
  end

  assign hit   = |match;
  assign full  = (cnt_q == DEPTH_C);
  assign count = cnt_q;

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C);
  assert_valid_tracks_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q));
  assert_clear_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (cnt_q == '0));
endmodule

// File: rtl/aom_seq_ctrl.sv
module aom_seq_ctrl
  import aom_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] in_op,
  input  logic       in_lock,
  input  logic       hit,
  input  logic       full,
  output logic       ins_en,
  output logic       clr_en,
  output logic       active,
  output logic       done,
  output logic       flt,
  output logic [2:0] cause,
  output logic       warn
);
  phase_e ph_q, ph_d;
  logic   done_q, done_d;
  logic   flt_q, flt_d;
  cause_e cause_q, cause_d;
  logic   warn_q, warn_d;
  logic   kill;
  cause_e kcause;
  logic   finish;
  op_e    op;

  assign op = op_e'(in_op);

  always_comb begin
    ph_d    = ph_q;
    ins_en  = 1'b0;
    warn_d  = warn_q;
    kill    = 1'b0;
    kcause  = CZ_NONE;
    finish  = 1'b0;
    if (in_valid) begin
      if (ph_q == PH_IDLE) begin
        if (op == OP_LOAD && in_lock) begin
          ins_en = 1'b1;
          ph_d   = PH_SETUP;
          warn_d = 1'b0;
        end
      end else begin
        case (op)
          OP_LOAD: begin
            if (in_lock) begin
              if (ph_q == PH_MANIF) begin
                kill = 1'b1; kcause = CZ_ORDER;
              end else if (!hit) begin
                if (full) begin
                  kill = 1'b1; kcause = CZ_CAPACITY;
                end else begin
                  ins_en = 1'b1;
                end
              end
            end else if (ph_q == PH_MANIF) begin
              warn_d = 1'b1;
            end
          end
          OP_QUERY: begin
            if (ph_q == PH_SETUP) ph_d = PH_MANIF;
            else begin
              kill = 1'b1; kcause = CZ_ORDER;
            end
          end
          OP_STORE: begin
            if (!hit) begin
              kill = 1'b1; kcause = CZ_FOREIGN;
            end else if (in_lock) begin
              finish = 1'b1;
            end else begin
              ph_d = PH_MANIF;
            end
          end
          default: ;
        endcase
      end
    end
    clr_en  = kill || finish;
    done_d  = finish;
    flt_d   = kill;
    cause_d = kcause;
    if (clr_en) ph_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      done_q  <= 1'b0;
      flt_q   <= 1'b0;
      cause_q <= CZ_NONE;
      warn_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      done_q  <= done_d;
      flt_q   <= flt_d;
      cause_q <= cause_d;
      if (warn_d != warn_q) warn_q <= warn_d;
    end
  end

  assign active = (ph_q != PH_IDLE);
  assign done   = done_q;
  assign flt    = flt_q;
  assign cause  = cause_q;
  assign warn   = warn_q;

  assert_done_ends_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (ph_q == PH_IDLE));
  assert_done_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && flt_q));
  assert_fault_ends_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q |-> (ph_q == PH_IDLE));
  assert_fault_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q |=> !flt_q);
  assert_cause_coded_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q == (cause_q != CZ_NONE));
  assert_warn_needs_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_q) |-> (ph_q == PH_MANIF));
endmodule

// File: rtl/atomic_order_monitor.sv
module atomic_order_monitor #(
  parameter int ADDR_W   = 48,
  parameter int LINE_OFS = 6,
  parameter int DEPTH    = 8,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic              in_lock,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              evt_active,
  output logic              evt_done,
  output logic              flt_pulse,
  output logic [2:0]        flt_cause,
  output logic              late_load_warn,
  output logic [CNT_W-1:0]  line_count
);
  localparam int TAG_W = ADDR_W - LINE_OFS;

  logic [TAG_W-1:0] tag;
  logic             hit, full, ins_en, clr_en;
  logic [LINE_OFS-1:0] ofs_unused;

  assign tag        = in_addr[ADDR_W-1:LINE_OFS];
  assign ofs_unused = in_addr[LINE_OFS-1:0];

  aom_line_table #(.TAG_W(TAG_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_table (
    .clk(clk), .rst_n(rst_n), .lookup_tag(tag), .ins_en(ins_en),
    .clr_en(clr_en), .hit(hit), .full(full), .count(line_count)
  );

  aom_seq_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_lock(in_lock), .hit(hit), .full(full), .ins_en(ins_en),
    .clr_en(clr_en), .active(evt_active), .done(evt_done),
    .flt(flt_pulse), .cause(flt_cause), .warn(late_load_warn)
  );

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || in_op == 2'd3) |=> ($stable(line_count) && $stable(evt_active)));
endmodule

// File: tb/test_atomic_order_monitor.sv
module test_atomic_order_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 48;
  localparam int CNT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [1:0]        in_op = 2'd3;
  logic              in_lock = 1'b0;
  logic [ADDR_W-1:0] in_addr = '0;
  logic              evt_active, evt_done, flt_pulse, late_load_warn;
  logic [2:0]        flt_cause;
  logic [CNT_W-1:0]  line_count;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_order_monitor i_atomic_order_monitor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_lock(in_lock), .in_addr(in_addr), .evt_active(evt_active),
    .evt_done(evt_done), .flt_pulse(flt_pulse), .flt_cause(flt_cause),
    .late_load_warn(late_load_warn), .line_count(line_count)
  );

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, QY = 2'd2, OT = 2'd3;
  localparam logic [ADDR_W-1:0] LA = 48'h1000, LB = 48'h2040, LC = 48'h30C0;

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic beat(logic v, logic [1:0] op, logic lk, logic [ADDR_W-1:0] a);
    @(negedge clk);
    in_valid = v; in_op = op; in_lock = lk; in_addr = a;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_state(string req, int act_e, int cnt, int done_e, int flt_e, int cz);
    check(req, "evt_active", int'(evt_active), act_e);
    check(req, "line_count", int'(line_count), cnt);
    check(req, "evt_done", int'(evt_done), done_e);
    check(req, "flt_pulse", int'(flt_pulse), flt_e);
    check(req, "flt_cause", int'(flt_cause), cz);
  endtask

  task automatic t_reset;
    expect_state("R1", 0, 0, 0, 0, 0);
    check("R1", "late_load_warn", int'(late_load_warn), 0);
  endtask

  task automatic t_idle_ignore;
    beat(1, ST, 1, LA); expect_state("R2", 0, 0, 0, 0, 0);
    beat(1, QY, 0, LA); expect_state("R2", 0, 0, 0, 0, 0);
    beat(1, LD, 0, LA); expect_state("R2", 0, 0, 0, 0, 0);
    beat(1, OT, 1, LA); expect_state("R11", 0, 0, 0, 0, 0);
  endtask

  task automatic t_basic;
    beat(1, LD, 1, LA);        expect_state("R2", 1, 1, 0, 0, 0);
    beat(1, LD, 1, LA + 8);    expect_state("R3", 1, 1, 0, 0, 0);
    beat(1, LD, 1, LA + 64);   expect_state("R3", 1, 2, 0, 0, 0);
    beat(1, OT, 1, LC);        expect_state("R11", 1, 2, 0, 0, 0);
    beat(0, LD, 1, LC);        expect_state("R11", 1, 2, 0, 0, 0);
    beat(1, LD, 0, LB);        check("R10", "warn in setup", int'(late_load_warn), 0);
    beat(1, ST, 1, LA + 100);  expect_state("R9", 0, 0, 1, 0, 0);
    beat(0, OT, 0, '0);        expect_state("R9", 0, 0, 0, 0, 0);
  endtask

  task automatic t_query_order;
    beat(1, LD, 1, LA); beat(1, LD, 1, LB);
    beat(1, QY, 0, '0);  expect_state("R5", 1, 2, 0, 0, 0);
    beat(1, LD, 1, LC);  expect_state("R5", 0, 0, 0, 1, 1);
    beat(0, OT, 0, '0);  expect_state("R12", 0, 0, 0, 0, 0);
  endtask

  task automatic t_store_manif;
    beat(1, LD, 1, LA);
    beat(1, ST, 0, LA + 4); expect_state("R6", 1, 1, 0, 0, 0);
    beat(1, LD, 1, LA);     expect_state("R6", 0, 0, 0, 1, 1);
  endtask

  task automatic t_query_faults;
    beat(1, LD, 1, LA); beat(1, QY, 0, '0);
    beat(1, QY, 0, '0);  expect_state("R7", 0, 0, 0, 1, 1);
    beat(1, LD, 1, LA); beat(1, ST, 0, LA);
    beat(1, QY, 0, '0);  expect_state("R7", 0, 0, 0, 1, 1);
  endtask

  task automatic t_foreign;
    beat(1, LD, 1, LA);
    beat(1, ST, 0, LB);  expect_state("R8", 0, 0, 0, 1, 3);
    beat(1, LD, 1, LA); beat(1, QY, 0, '0);
    beat(1, ST, 1, LB);  expect_state("R8", 0, 0, 0, 1, 3);
  endtask

  task automatic t_capacity;
    for (int i = 0; i < 8; i++) beat(1, LD, 1, LA + ADDR_W'(i * 64));
    expect_state("R4", 1, 8, 0, 0, 0);
    beat(1, LD, 1, LA + 7 * 64 + 3); expect_state("R4", 1, 8, 0, 0, 0);
    beat(1, LD, 1, LA + 8 * 64);     expect_state("R4", 0, 0, 0, 1, 2);
    beat(0, OT, 0, '0);              expect_state("R12", 0, 0, 0, 0, 0);
  endtask

  task automatic t_warn;
    beat(1, LD, 1, LA); beat(1, QY, 0, '0);
    beat(1, LD, 0, LB);
    check("R10", "warn set", int'(late_load_warn), 1);
    expect_state("R10", 1, 1, 0, 0, 0);
    beat(1, ST, 1, LA);  expect_state("R10", 0, 0, 1, 0, 0);
    check("R10", "warn held", int'(late_load_warn), 1);
    beat(1, LD, 1, LC);  check("R10", "warn cleared", int'(late_load_warn), 0);
    beat(1, ST, 1, LC);  expect_state("R9", 0, 0, 1, 0, 0);
  endtask

  task automatic t_setup_complete;
    beat(1, LD, 1, LB); beat(1, LD, 1, LC);
    beat(1, ST, 1, LB + 1); expect_state("R9", 0, 0, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_idle_ignore();
    t_basic();
    t_query_order();
    t_store_manif();
    t_query_faults();
    t_foreign();
    t_capacity();
    t_warn();
    t_setup_complete();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule